// File: doc/BRIEF.md
# UART Interrupt Identification

This block sits between the five interrupt sources of a UART channel and the host. It collects events from the receive line error detector, the receive buffer, the receive idle timer, the transmit holding stage and the modem input change detector. It masks them with four enable bits and reports only the most urgent one. The report is a 4-bit identification code inside an 8-bit status byte, plus a single interrupt request line.

Line errors, modem input changes and receive timeouts arrive as one-cycle pulses. The block stores them until the host reads the matching register. Receive data availability is a level input. The transmit-empty interrupt arms on a rising edge of the empty condition, or when its enable bit is turned on while the holding stage is already empty. It is withdrawn when the host reads the status byte while that source is the one shown, or when the host writes new transmit data.

Status byte and request line are registered. Every stimulus sampled at a rising clock edge is reflected on the outputs right after that same edge.

Top module: `uart_intid`

## Requirements
- R1: While reset is asserted and right after it, the status byte reads 8'h01 and irq_o is low.
- R2: Status bit 0 is 0 when some enabled source is pending and 1 when none is. irq_o is high exactly when status bit 0 is 0.
- R3: Status bits 3:0 carry the code of the highest pending enabled source. The codes are 4'b0110 for a line error, 4'b0100 for receive data available, 4'b1100 for receive timeout, 4'b0010 for transmit empty and 4'b0000 for a modem change. With nothing pending they read 4'b0001. Urgency falls in that order, except that data available and timeout share the second level.
- R4: When receive data available and receive timeout are both pending, data available is reported. A timeout is reported only while fifo_en_i is 1.
- R5: int_en_i bit 0 gates both the data available and the timeout interrupts, bit 1 gates transmit empty, bit 2 gates line errors, and bit 3 gates modem changes. With int_en_i at 0 the status byte bit 0 stays 1.
- R6: Status bits 7:6 both equal fifo_en_i, and bits 5:4 are always 0.
- R7: A line error pulse is held until line_stat_rd_i, and a modem change pulse is held until modem_stat_rd_i. A new event in the same cycle as its clearing read wins.
- R8: Transmit empty arms on a rising edge of tx_hold_empty_i, or on a rising edge of int_en_i bit 1 while tx_hold_empty_i is 1. It clears on tx_hold_wr_i, or on int_id_rd_i while the status byte shows code 4'b0010 with bit 0 low.
- R9: A status byte read while another source is shown does not clear a pending transmit-empty interrupt, and it never clears line, modem or timeout events.
- R10: A receive timeout pulse is held until rx_data_rd_i.
- R11: Every output change caused by inputs sampled at a rising edge appears after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_err_set_i | input | 1 | Pulse: receive line error detected |
| rx_avail_i | input | 1 | Level: receive data available |
| rx_tmo_set_i | input | 1 | Pulse: receive idle timeout expired |
| tx_hold_empty_i | input | 1 | Level: transmit holding stage empty |
| modem_chg_set_i | input | 1 | Pulse: modem input changed |
| int_en_i | input | 4 | Interrupt enables (bit 0 receive, 1 transmit, 2 line error, 3 modem) |
| fifo_en_i | input | 1 | FIFO mode enabled |
| int_id_rd_i | input | 1 | Host read of the status byte |
| line_stat_rd_i | input | 1 | Host read of the line status register |
| modem_stat_rd_i | input | 1 | Host read of the modem status register |
| rx_data_rd_i | input | 1 | Host read of received data |
| tx_hold_wr_i | input | 1 | Host write of transmit data |
| int_id_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
All results, including the clearing effect of a read, are due one rising edge after the stimulus is applied, because the status byte is registered from next-state values. The bench changes inputs on the falling edge and reads the outputs on the following falling edge. That way every check lands half a cycle after the edge that produced its result. Multi-step servicing sequences check the status byte after each read, one edge at a time.

// File: rtl/uart_intid_pkg.sv
package uart_intid_pkg;

    localparam int STAT_W = 8;
    localparam int ID_W   = 4;
    localparam int NSRC   = 5;

    localparam logic [ID_W-1:0] ID_LINE  = 4'b0110;
    localparam logic [ID_W-1:0] ID_RXRDY = 4'b0100;
    localparam logic [ID_W-1:0] ID_TMO   = 4'b1100;
    localparam logic [ID_W-1:0] ID_TXE   = 4'b0010;
    localparam logic [ID_W-1:0] ID_MODEM = 4'b0000;
    localparam logic [ID_W-1:0] ID_IDLE  = 4'b0001;

    // index order is urgency order: lower index wins
    typedef enum logic [2:0] {
        SRC_LINE  = 3'd0,
        SRC_RXRDY = 3'd1,
        SRC_TMO   = 3'd2,
        SRC_TXE   = 3'd3,
        SRC_MODEM = 3'd4,
        SRC_NONE  = 3'd5
    } src_e;

    function automatic logic [ID_W-1:0] src_code(input src_e s);
        case (s)
            SRC_LINE:  return ID_LINE;
            SRC_RXRDY: return ID_RXRDY;
            SRC_TMO:   return ID_TMO;
            SRC_TXE:   return ID_TXE;
            SRC_MODEM: return ID_MODEM;
            default:   return ID_IDLE;
        endcase
    endfunction

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic              irq;
    } out_st_t;

endpackage

// File: rtl/intid_sticky.sv
module intid_sticky #(
    parameter int N = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_d_o,
    output logic [N-1:0] flag_q_o
);

    logic [N-1:0] flag_d, flag_q;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            flag_d[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flag_q <= '0;
        else         flag_q <= flag_d;
    end

    assign flag_d_o = flag_d;
    assign flag_q_o = flag_q;

endmodule

// File: rtl/intid_txe_arm.sv
module intid_txe_arm (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic empty_i,
    input  logic en_i,
    input  logic shown_rd_i,
    input  logic hold_wr_i,
    output logic pend_d_o
);

    typedef struct packed {
        logic empty_prev;
        logic en_prev;
        logic pend;
    } txe_st_t;

    txe_st_t st_d, st_q;
    logic    arm, clr;

    always_comb begin
        arm             = (empty_i & ~st_q.empty_prev) | (en_i & ~st_q.en_prev & empty_i);
        clr             = hold_wr_i | shown_rd_i;
        st_d.empty_prev = empty_i;
        st_d.en_prev    = en_i;
        st_d.pend       = arm | (st_q.pend & ~clr);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign pend_d_o = st_d.pend;

endmodule

// File: rtl/intid_prio_enc.sv
module intid_prio_enc
    import uart_intid_pkg::*;
(
    input  logic [NSRC-1:0] req_i,
    output src_e            src_o,
    output logic [ID_W-1:0] code_o,
    output logic            any_o
);

    always_comb begin
        src_o = SRC_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_i[i]) src_o = src_e'(i);
        end
        code_o = src_code(src_o);
        any_o  = |req_i;
    end

endmodule

// File: rtl/uart_intid.sv
module uart_intid
    import uart_intid_pkg::*;
#(
    parameter int EN_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              line_err_set_i,
    input  logic              rx_avail_i,
    input  logic              rx_tmo_set_i,
    input  logic              tx_hold_empty_i,
    input  logic              modem_chg_set_i,
    input  logic [EN_W-1:0]   int_en_i,
    input  logic              fifo_en_i,
    input  logic              int_id_rd_i,
    input  logic              line_stat_rd_i,
    input  logic              modem_stat_rd_i,
    input  logic              rx_data_rd_i,
    input  logic              tx_hold_wr_i,
    output logic [STAT_W-1:0] int_id_o,
    output logic              irq_o
);

    localparam int NSTICKY = 3;
    localparam int K_LINE  = 0;
    localparam int K_MODEM = 1;
    localparam int K_TMO   = 2;

    out_st_t st_d, st_q;

    logic [NSTICKY-1:0] sticky_set, sticky_clr, sticky_d, sticky_q;
    logic               txe_pend_d, txe_shown_rd;
    logic [NSRC-1:0]    req;
    src_e               top_src;
    logic [ID_W-1:0]    top_code;
    logic               any_req;

    // stored events: line error, modem change, receive timeout
    assign sticky_set[K_LINE]  = line_err_set_i;
    assign sticky_clr[K_LINE]  = line_stat_rd_i;
    assign sticky_set[K_MODEM] = modem_chg_set_i;
    assign sticky_clr[K_MODEM] = modem_stat_rd_i;
    assign sticky_set[K_TMO]   = rx_tmo_set_i;
    assign sticky_clr[K_TMO]   = rx_data_rd_i;

    intid_sticky #(.N(NSTICKY)) u_sticky (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (sticky_set),
        .clr_i    (sticky_clr),
        .flag_d_o (sticky_d),
        .flag_q_o (sticky_q)
    );

    // host sees transmit-empty in the status byte it reads
    assign txe_shown_rd = int_id_rd_i & ~st_q.stat[0] & (st_q.stat[ID_W-1:0] == ID_TXE);

    intid_txe_arm u_txe (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .empty_i    (tx_hold_empty_i),
        .en_i       (int_en_i[1]),
        .shown_rd_i (txe_shown_rd),
        .hold_wr_i  (tx_hold_wr_i),
        .pend_d_o   (txe_pend_d)
    );

    always_comb begin
        req            = '0;
        req[SRC_LINE]  = sticky_d[K_LINE] & int_en_i[2];
        req[SRC_RXRDY] = rx_avail_i & int_en_i[0];
        req[SRC_TMO]   = sticky_d[K_TMO] & int_en_i[0] & fifo_en_i;
        req[SRC_TXE]   = txe_pend_d & int_en_i[1];
        req[SRC_MODEM] = sticky_d[K_MODEM] & int_en_i[3];
    end

    intid_prio_enc u_enc (
        .req_i  (req),
        .src_o  (top_src),
        .code_o (top_code),
        .any_o  (any_req)
    );

    always_comb begin
        st_d      = st_q;
        st_d.stat = {{2{fifo_en_i}}, 2'b00, top_code[ID_W-1:1], ~any_req};
        st_d.irq  = (top_src != SRC_NONE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.stat <= {{(STAT_W-1){1'b0}}, 1'b1};
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_id_o = st_q.stat;
    assign irq_o    = st_q.irq;

    logic unused_ok;
    assign unused_ok = ^{sticky_q, top_code[0]};

endmodule

// File: rtl/uart_intid_chk.sv
module uart_intid_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       line_err_set_i,
    input logic       rx_avail_i,
    input logic [3:0] int_en_i,
    input logic       fifo_en_i,
    input logic [7:0] int_id_o,
    input logic       irq_o
);

    logic armed_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    AST_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == !int_id_o[0]);                                              // R2
    AST_IDLE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_id_o[0] |-> int_id_o[3:1] == 3'b000);                           // R3
    AST_LEGAL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_id_o[3:0] inside {4'b0110, 4'b0100, 4'b1100, 4'b0010, 4'b0000, 4'b0001}); // R3
    AST_UPPER_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q |-> (int_id_o[7:6] == {2{$past(fifo_en_i)}}) && (int_id_o[5:4] == 2'b00)); // R6
    AST_LINE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && $past(line_err_set_i && int_en_i[2]) |-> int_id_o[3:0] == 4'b0110); // R7
    AST_MASK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && $past(int_en_i == 4'b0000) |-> int_id_o[0]);              // R5
    AST_RX_OVER_LOWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && $past(rx_avail_i && int_en_i[0]) |->
        (int_id_o[3:0] == 4'b0110) || (int_id_o[3:0] == 4'b0100));           // R4
    AST_TMO_FIFO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q && $past(!fifo_en_i) |-> int_id_o[3:0] != 4'b1100);          // R4

endmodule

bind uart_intid uart_intid_chk u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .line_err_set_i (line_err_set_i),
    .rx_avail_i     (rx_avail_i),
    .int_en_i       (int_en_i),
    .fifo_en_i      (fifo_en_i),
    .int_id_o       (int_id_o),
    .irq_o          (irq_o)
);

// File: tb/uart_intid_tb_top.sv
module uart_intid_tb_top;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       line_err_set_i = 1'b0, rx_avail_i = 1'b0, rx_tmo_set_i = 1'b0;
    logic       tx_hold_empty_i = 1'b0, modem_chg_set_i = 1'b0;
    logic [3:0] int_en_i = 4'b0000;
    logic       fifo_en_i = 1'b0;
    logic       int_id_rd_i = 1'b0, line_stat_rd_i = 1'b0, modem_stat_rd_i = 1'b0;
    logic       rx_data_rd_i = 1'b0, tx_hold_wr_i = 1'b0;
    logic [7:0] int_id_o;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk_i = ~clk_i;

    uart_intid dut_i (
        .clk_i, .rst_ni, .line_err_set_i, .rx_avail_i, .rx_tmo_set_i,
        .tx_hold_empty_i, .modem_chg_set_i, .int_en_i, .fifo_en_i,
        .int_id_rd_i, .line_stat_rd_i, .modem_stat_rd_i, .rx_data_rd_i,
        .tx_hold_wr_i, .int_id_o, .irq_o
    );

    // en[17:14] fifo[13] rx[12] txe[11] lerr[10] mchg[9] tmo[8] expected[7:0]
    localparam int NV = 12;
    localparam logic [17:0] VEC [NV] = '{
        {4'b0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'h01}, // R5 all masked
        {4'b1111, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hC6}, // R3 line first
        {4'b1011, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hC4}, // R4 data over timeout
        {4'b1011, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hCC}, // R3 timeout
        {4'b1011, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h02}, // R4 no timeout w/o fifo
        {4'b1010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h02}, // R3 tx over modem
        {4'b1000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00}, // R5 modem only enabled
        {4'b0100, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hC6}, // R5 line enable
        {4'b0001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC4}, // R5 receive enable
        {4'b1111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hC1}, // R6 idle fifo mode
        {4'b0111, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01}, // R5 modem masked
        {4'b0010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'hC2}  // R8 tx empty edge
    };

    task automatic chk(input string req, input logic [7:0] exp);
        n_chk++;
        if (int_id_o !== exp || irq_o !== ~exp[0]) begin
            n_bad++;
            $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                     req, int_id_o, irq_o, exp, ~exp[0]);
        end
    endtask

    task automatic clear_pulses();
        line_err_set_i = 0; rx_tmo_set_i = 0; modem_chg_set_i = 0;
        int_id_rd_i = 0; line_stat_rd_i = 0; modem_stat_rd_i = 0;
        rx_data_rd_i = 0; tx_hold_wr_i = 0;
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_ni = 0;
        clear_pulses();
        rx_avail_i = 0; tx_hold_empty_i = 0; int_en_i = 0; fifo_en_i = 0;
        @(negedge clk_i);
        rst_ni = 1;
    endtask

    // apply current inputs across one rising edge, then check (R11)
    task automatic step(input string req, input logic [7:0] exp);
        @(negedge clk_i);
        chk(req, exp);
        clear_pulses();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: status=%h irq=%b expected completion", int_id_o, irq_o);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 during and after reset
        repeat (2) @(negedge clk_i);
        chk("R1 in reset", 8'h01);
        rst_ni = 1;
        @(negedge clk_i);
        chk("R1 after reset", 8'h01);

        for (int v = 0; v < NV; v++) begin
            do_reset();
            int_en_i        = VEC[v][17:14];
            fifo_en_i       = VEC[v][13];
            rx_avail_i      = VEC[v][12];
            tx_hold_empty_i = VEC[v][11];
            line_err_set_i  = VEC[v][10];
            modem_chg_set_i = VEC[v][9];
            rx_tmo_set_i    = VEC[v][8];
            step("R2 R3 R11 vector", VEC[v][7:0]);
        end

        // R7 line error stays, read clears, set wins
        do_reset();
        int_en_i = 4'b0100; line_err_set_i = 1;
        step("R7 line set", 8'h06);
        step("R7 line held", 8'h06);
        line_stat_rd_i = 1;
        step("R7 line cleared", 8'h01);
        line_err_set_i = 1; line_stat_rd_i = 1;
        step("R7 set beats clear", 8'h06);

        // R3 servicing order
        do_reset();
        int_en_i = 4'b1111; tx_hold_empty_i = 1; line_err_set_i = 1; modem_chg_set_i = 1;
        step("R3 line shown", 8'h06);
        line_stat_rd_i = 1;
        step("R3 tx next", 8'h02);
        int_id_rd_i = 1;
        step("R8 status read clears tx", 8'h00);
        modem_stat_rd_i = 1;
        step("R7 modem cleared", 8'h01);

        // R9 status read while line shown keeps tx
        do_reset();
        int_en_i = 4'b1111; tx_hold_empty_i = 1; line_err_set_i = 1;
        step("R9 line shown", 8'h06);
        int_id_rd_i = 1;
        step("R9 read keeps line", 8'h06);
        line_stat_rd_i = 1;
        step("R9 tx survived", 8'h02);

        // R8 write clears, enable re-arms
        do_reset();
        int_en_i = 4'b0010; tx_hold_empty_i = 1;
        step("R8 armed", 8'h02);
        tx_hold_wr_i = 1;
        step("R8 write clears", 8'h01);
        step("R8 stays clear on level", 8'h01);
        int_en_i = 4'b0000;
        step("R8 disabled", 8'h01);
        int_en_i = 4'b0010;
        step("R8 enable re-arms", 8'h02);

        // R10 timeout held until receive read
        do_reset();
        int_en_i = 4'b0001; fifo_en_i = 1; rx_tmo_set_i = 1;
        step("R10 timeout set", 8'hCC);
        step("R10 timeout held", 8'hCC);
        int_id_rd_i = 1;
        step("R9 status read keeps timeout", 8'hCC);
        rx_data_rd_i = 1;
        step("R10 receive read clears", 8'hC1);

        // R6 upper bits follow fifo mode
        fifo_en_i = 0;
        step("R6 fifo off", 8'h01);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule